// File: doc/BRIEF.md
# Streaming Pairwise Sum Unit

This block takes a stream of 8-bit unsigned samples, one for each single-cycle strobe. For every accepted sample it produces the sum of two samples it has seen. The result is registered and carries a flag that marks it as meaningful. A 2-bit mode input picks how samples are paired. In sliding mode each sample is added to the one just before it. In block mode samples are taken as disjoint back-to-back pairs. In lag-two mode each sample is added to the one two places earlier.

The unit keeps a short history of past samples, a count of accepted samples that saturates, and a pair phase bit. From these it decides whether the new sum is meaningful. The sum is one bit wider than a sample, so it never wraps. The mode is changed only while reset is held. After a change made in mid-stream the behaviour is not defined.

Top module: `pair_sum_stream`

## Requirements
- R1: With mode code 0 (sliding), every accepted sample n gives out_sum = in(n) + in(n-1). out_ready is high for every sample from the second one on after reset.
- R2: In every mode, the first sample accepted after reset gives out_ready low.
- R3: out_sum is 9 bits wide and holds the exact sum without wrapping. The samples 255 and 255 give 510.
- R4: With mode code 1 (block), samples are grouped in pairs (1,2), (3,4) and so on. out_ready is high only for the second sample of a pair, and out_sum is then the sum of that pair. The pairing restarts at reset.
- R5: With mode code 2 (lag-two), every accepted sample n gives out_sum = in(n) + in(n-2). out_ready is low for the first two samples after reset.
- R6: Each strobe updates the outputs exactly one clock later. out_ready is high for that one cycle only. In a cycle that follows no strobe, out_ready is low and out_sum keeps its value.
- R7: Synchronous active-high reset sets out_ready and out_sum to 0 and clears the sample history, the sample count and the pair phase. Samples taken before reset never show up in a sum after it.
- R8: Mode code 3 is reserved. With it, out_ready stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Pairing rule: 0 sliding, 1 block, 2 lag-two, 3 reserved |
| in_valid | input | 1 | Single-cycle strobe that accepts in_data |
| in_data | input | DATA_W (8) | Unsigned input sample |
| out_sum | output | DATA_W+1 (9) | Registered sum of the selected pair |
| out_ready | output | 1 | High for one cycle when out_sum is meaningful |

## Verification
The assertions check the flag rules on every cycle. A cycle with no strobe leaves the sum held and the flag low. The first sample never gives a valid flag. In block mode the phase flips on each sample and the flag stays low on the first of a pair. In lag-two mode the flag stays low on the early samples. The reserved code never raises the flag. The sum never falls below the sample just taken. The actual sum values need a reference model, so only the bench scenarios can show them. These scenarios are the stated example stream in every mode, the 255+255 extreme, a reset that cuts a stream in the middle, and random streams with random idle gaps.

// File: rtl/pair_sum_pkg.sv
package pair_sum_pkg;
  typedef enum logic [1:0] {
    PAIR_SLIDE = 2'd0,
    PAIR_BLOCK = 2'd1,
    PAIR_LAG2  = 2'd2,
    PAIR_RSVD  = 2'd3
  } pair_mode_e;

  localparam int unsigned HIST_DEPTH = 2;
endpackage

// File: rtl/pair_sum_hist.sv
// Shift chain of past samples: tap[0] is the latest, tap[DEPTH-1] the oldest.
module pair_sum_hist #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shift_en,
  input  logic [DATA_W-1:0]             din,
  output logic [DEPTH-1:0][DATA_W-1:0]  taps
);
  logic [DATA_W-1:0] stage_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    logic [DATA_W-1:0] stage_d;
    if (gi == 0) begin : g_head
      assign stage_d = din;
    end else begin : g_body
      assign stage_d = stage_q[gi-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[gi] <= '0;
      end else if (shift_en) begin
        stage_q[gi] <= stage_d;
      end
    end

    assign taps[gi] = stage_q[gi];
  end
endmodule

// File: rtl/pair_sum_qual.sv
// Tracks how many samples have arrived and the pair phase, and decides
// whether the sum formed from the current sample is meaningful.
module pair_sum_qual
  import pair_sum_pkg::*;
#(
  parameter int unsigned CNT_MAX = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic [1:0] mode,
  output logic       seen_one,
  output logic       seen_two,
  output logic       phase,
  output logic       use_lag2,
  output logic       result_ok
);
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  pair_mode_e       mode_e;

  assign mode_e = pair_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (accept) begin
      phase_q <= ~phase_q;
      if (cnt_q != CNT_W'(CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign seen_one = (cnt_q >= CNT_W'(1));
  assign seen_two = (cnt_q >= CNT_W'(2));
  assign phase    = phase_q;
  assign use_lag2 = (mode_e == PAIR_LAG2);

  always_comb begin
    unique case (mode_e)
      PAIR_SLIDE: result_ok = seen_one;
      PAIR_BLOCK: result_ok = phase_q;
      PAIR_LAG2:  result_ok = seen_two;
      default:    result_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pair_sum_outreg.sv
// Forms the widened sum and registers it with the one-cycle ready pulse.
module pair_sum_outreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              result_ok,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] partner,
  output logic [DATA_W:0]   sum_q,
  output logic              ready_q
);
  function automatic logic [DATA_W:0] wide_add(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= accept & result_ok;
      if (accept) begin
        sum_q <= wide_add(sample, partner);
      end
    end
  end
endmodule

// File: rtl/pair_sum_stream.sv
module pair_sum_stream
  import pair_sum_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W:0]   out_sum,
  output logic              out_ready
);
  localparam int unsigned DEPTH = HIST_DEPTH;

  logic                         accept;
  logic [DEPTH-1:0][DATA_W-1:0] taps;
  logic [DATA_W-1:0]            partner;
  logic                         seen_one;
  logic                         seen_two;
  logic                         phase;
  logic                         use_lag2;
  logic                         result_ok;

  assign accept  = in_valid;
  assign partner = use_lag2 ? taps[1] : taps[0];

  pair_sum_hist #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst(rst), .shift_en(accept), .din(in_data), .taps(taps)
  );

  pair_sum_qual #(.CNT_MAX(DEPTH)) u_qual (
    .clk(clk), .rst(rst), .accept(accept), .mode(mode),
    .seen_one(seen_one), .seen_two(seen_two), .phase(phase),
    .use_lag2(use_lag2), .result_ok(result_ok)
  );

  pair_sum_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .accept(accept), .result_ok(result_ok),
    .sample(in_data), .partner(partner), .sum_q(out_sum), .ready_q(out_ready)
  );
endmodule

// File: rtl/pair_sum_chk.sv
module pair_sum_chk
  import pair_sum_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [DATA_W:0]   out_sum,
  input logic              out_ready,
  input logic              seen_one,
  input logic              seen_two,
  input logic              phase
);
  p_slide_ready_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == PAIR_SLIDE && seen_one) |=> out_ready);

  p_first_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !seen_one) |=> !out_ready);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_sum >= {1'b0, $past(in_data)}));

  p_block_first_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == PAIR_BLOCK && !phase) |=> !out_ready);

  p_phase_flip_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (phase != $past(phase)));

  p_lag_early_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == PAIR_LAG2 && !seen_two) |=> !out_ready);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_ready && $stable(out_sum)));

  p_rsvd_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == PAIR_RSVD && $past(mode) == PAIR_RSVD) |-> !out_ready);
endmodule

bind pair_sum_stream pair_sum_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_data(in_data),
  .out_sum(out_sum), .out_ready(out_ready), .seen_one(seen_one),
  .seen_two(seen_two), .phase(phase)
);

// File: tb/pair_sum_stream_tb.sv
`timescale 1ns/1ps
module pair_sum_stream_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [8:0] out_sum;
  logic       out_ready;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pair_sum_stream #(.DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
    .in_data(in_data), .out_sum(out_sum), .out_ready(out_ready)
  );

  // Scoreboard queues
  bit       q_rdy[$];
  int       q_sum[$];
  string    q_tag[$];

  // Bench reference model
  int m_p1, m_p2, m_cnt;
  bit m_phase;

  task automatic model_clear();
    m_p1 = 0; m_p2 = 0; m_cnt = 0; m_phase = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d[7:0];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Update the model and return its view of the result.
  task automatic model_step(input int d, output bit rdy, output int s);
    case (mode)
      2'd0: begin rdy = (m_cnt >= 1); s = d + m_p1; end
      2'd1: begin rdy = m_phase;      s = d + m_p1; end
      2'd2: begin rdy = (m_cnt >= 2); s = d + m_p2; end
      default: begin rdy = 1'b0;      s = d + m_p1; end
    endcase
    m_p2 = m_p1; m_p1 = d;
    if (m_cnt < 2) m_cnt++;
    m_phase = ~m_phase;
  endtask

  // Directed: expectation supplied by hand, model still tracked.
  task automatic send_exp(input int d, input bit rdy, input int s, input string tag);
    bit r; int ms;
    model_step(d, r, ms);
    q_rdy.push_back(rdy); q_sum.push_back(s); q_tag.push_back(tag);
    drive(d);
  endtask

  task automatic send_model(input int d, input string tag);
    bit r; int ms;
    model_step(d, r, ms);
    q_rdy.push_back(r); q_sum.push_back(ms); q_tag.push_back(tag);
    drive(d);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1;
    mode = m;
    repeat (2) @(negedge clk);
    check(out_ready == 1'b0, "R7 reset ready", out_ready, 0);
    check(out_sum == 9'd0, "R7 reset sum", out_sum, 0);
    rst = 1'b0;
    model_clear();
  endtask

  // Monitor
  logic pend = 1'b0;
  logic [8:0] last_sum = '0;
  always @(posedge clk) pend <= in_valid && !rst;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (pend) begin
        if (q_rdy.size() == 0) begin
          check(1'b0, "R6 unexpected update", 1, 0);
        end else begin
          bit er; int es; string et;
          er = q_rdy.pop_front(); es = q_sum.pop_front(); et = q_tag.pop_front();
          check(out_ready == er, {et, " ready"}, out_ready, er);
          if (er) check(out_sum == es[8:0], {et, " sum"}, out_sum, es);
        end
      end else begin
        check(out_ready == 1'b0, "R6 idle ready", out_ready, 0);
        check(out_sum == last_sum, "R6 idle hold", out_sum, last_sum);
      end
    end
    last_sum = out_sum;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s_in[6];
    s_in = '{34, 2, 67, 8, 213, 3};
    model_clear();

    // R1 sliding example
    do_reset(2'd0);
    send_exp(s_in[0], 0, 0, "R2 slide first");
    send_exp(s_in[1], 1, 36, "R1 slide");
    send_exp(s_in[2], 1, 69, "R1 slide");
    send_exp(s_in[3], 1, 75, "R1 slide");
    send_exp(s_in[4], 1, 221, "R1 slide");
    send_exp(s_in[5], 1, 216, "R1 slide");
    repeat (2) @(negedge clk);

    // R4 block example
    do_reset(2'd1);
    send_exp(s_in[0], 0, 0, "R2 block first");
    send_exp(s_in[1], 1, 36, "R4 block");
    send_exp(s_in[2], 0, 0, "R4 block");
    send_exp(s_in[3], 1, 75, "R4 block");
    send_exp(s_in[4], 0, 0, "R4 block");
    send_exp(s_in[5], 1, 216, "R4 block");
    repeat (2) @(negedge clk);

    // R5 lag-two example
    do_reset(2'd2);
    send_exp(s_in[0], 0, 0, "R2 lag first");
    send_exp(s_in[1], 0, 0, "R5 lag second");
    send_exp(s_in[2], 1, 101, "R5 lag");
    send_exp(s_in[3], 1, 10, "R5 lag");
    send_exp(s_in[4], 1, 280, "R5 lag");
    send_exp(s_in[5], 1, 11, "R5 lag");

    // R7: reset mid-stream clears history
    send_exp(200, 1, 413, "R5 lag");
    do_reset(2'd2);
    send_exp(1, 0, 0, "R7 after reset");
    send_exp(2, 0, 0, "R7 after reset");
    send_exp(3, 1, 4, "R7 history cleared");

    // R3 extreme
    do_reset(2'd0);
    send_exp(255, 0, 0, "R2 slide first");
    send_exp(255, 1, 510, "R3 no wrap");

    // R8 reserved code
    do_reset(2'd3);
    for (int i = 0; i < 5; i++) send_exp(10 + i, 0, 0, "R8 reserved");

    // Random streams in each mode
    for (int m = 0; m < 3; m++) begin
      do_reset(m[1:0]);
      for (int i = 0; i < 200; i++) begin
        int gap;
        send_model($urandom_range(0, 255), m == 0 ? "R1 random" : (m == 1 ? "R4 random" : "R5 random"));
        gap = $urandom_range(0, 2);
        repeat (gap) @(negedge clk);
      end
    end

    repeat (3) @(negedge clk);
    check(q_rdy.size() == 0, "R6 queue drained", q_rdy.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule